// File: doc/BRIEF.md
# Flash Command Interface Controller

This block models the command side of a parallel NOR-style flash part placed in front of an internal storage array. A host on a simple synchronous bus (address, write data, read data, read strobe, write strobe) talks to it. Each write is taken either as a command byte or as an operand for the command in progress, depending on the current mode. The block supports array reads, identifier reads, a one-shot status read, status clear, single-location programming, a windowed buffered program with a confirm-or-discard step, and a block erase with a confirm step.

Buffered commits and block erases take several clock cycles, one location per cycle. While they run, a busy output is high and every bus access is ignored, so the host must wait until busy falls before it issues the next access. In word mode the byte address from the host is shifted right by one to form the word address. In byte mode the address is used as is. The array depth, block size, buffer size and identifier codes are parameters.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in array-read mode, `bus_rdata` is 0 and `bus_busy` is low.
- R2: A read in array-read mode returns, one cycle later on `bus_rdata`, the word stored at the word address. In word mode (WORD_MODE=1) the word address is `bus_addr >> 1`.
- R3: Only bits 7:0 of a written value are decoded as a command. A command byte outside {0x10, 0x20, 0x40, 0x50, 0x70, 0x90, 0xE8, 0xFF} leaves the mode unchanged.
- R4: Commands 0xFF and 0x50 both return the block to array-read mode.
- R5: Command 0x40 or 0x10 arms a single program. The next write stores its data at its word address and enters a program-done mode. In program-done mode a write is decoded as a command.
- R6: Command 0xE8 records its word address as the buffer start. The next write sets the entry count to (data & 0x1F) + 1.
- R7: While the buffer is filling, a write whose word address lies in [start, start+count) stores its data at entry (address − start) and counts as one accepted write. Other writes are ignored. After count accepted writes the block waits for a confirm.
- R8: At the confirm step, a write whose low byte is 0xD0 copies every buffer entry to consecutive words from the buffer start. Any other value discards the buffer. Both cases return to array-read mode.
- R9: Command 0x90 enters identifier mode. A read of word 0 returns MFR_CODE (0x89), a read of word 1 returns DEV_CODE, and a read of any other word returns 0. A write in this mode is decoded as a command.
- R10: Command 0x70 enters status mode. The next access ends the mode and returns to array-read mode. If that access is a read it returns 0x80. If it is a write, it is not decoded as a command.
- R11: Command 0x20 arms an erase. A write with low byte 0xD0 sets BLK words to all ones, starting at that write's word address and wrapping at the array end, then enters erase-done mode. In erase-done mode a write is decoded as a command. Any other write leaves the erase armed.
- R12: A read in program-armed, program-done, count, buffer-fill, confirm, erase-armed or erase-done mode returns 0x80.
- R13: A commit of N entries holds `bus_busy` high for N cycles, and an erase holds it high for BLK cycles. While busy, reads and writes have no effect and `bus_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Byte address (AW = log2(DEPTH) + WORD_MODE) |
| bus_wdata | input | DW | Write data or command (command in bits 7:0) |
| bus_wr | input | 1 | Write strobe (wins over bus_rd) |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DW | Registered read data, valid the cycle after a read |
| bus_busy | output | 1 | High while a commit or an erase is running |

## Verification
Read data is registered, so a read's value appears on `bus_rdata` one clock edge after the strobe. A command takes effect at the edge where it is written, and the next access already sees the new mode. `bus_busy` rises at the edge that accepts the 0xD0 confirm and stays high for exactly N (commit) or BLK (erase) observed cycles. The bench's behavioural model advances by exactly one edge for every access it drives and predicts both `bus_rdata` and `bus_busy` for the sample point half a period after that edge. Accesses issued while busy are included, so the model can show they were ignored.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    ST_ARRAY,
    ST_ID,
    ST_STATUS,
    ST_PROG,
    ST_PROG_DONE,
    ST_BUF_CNT,
    ST_BUF_DATA,
    ST_BUF_CONF,
    ST_COMMIT,
    ST_ERASE_ARM,
    ST_ERASING,
    ST_ERASE_DONE
  } fstate_e;

  localparam logic [7:0] CMD_PROG_A  = 8'h40;
  localparam logic [7:0] CMD_PROG_B  = 8'h10;
  localparam logic [7:0] CMD_BUFFER  = 8'hE8;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_RESET   = 8'hFF;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] READY_CODE  = 8'h80;

  // Map a command byte to the mode it selects; unknown bytes keep the mode.
  function automatic fstate_e decode_cmd(input logic [7:0] cmd, input fstate_e cur);
    fstate_e nxt;
    nxt = cur;
    case (cmd)
      CMD_PROG_A, CMD_PROG_B: nxt = ST_PROG;
      CMD_BUFFER:             nxt = ST_BUF_CNT;
      CMD_STATUS:             nxt = ST_STATUS;
      CMD_CLEAR, CMD_RESET:   nxt = ST_ARRAY;
      CMD_IDENT:              nxt = ST_ID;
      CMD_ERASE:              nxt = ST_ERASE_ARM;
      default:                nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/flash_mem.sv
module flash_mem #(
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  localparam int MAW  = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [MAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [MAW-1:0] raddr,
  output logic [DW-1:0]  rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/flash_wbuf.sv
module flash_wbuf #(
  parameter int DW      = 16,
  parameter int ENTRIES = 32,
  localparam int BIW    = $clog2(ENTRIES)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [BIW-1:0] widx,
  input  logic [DW-1:0]  wdata,
  input  logic [BIW-1:0] ridx,
  output logic [DW-1:0]  rdata
);
  logic [DW-1:0] slots [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) slots[widx] <= wdata;
  end

  assign rdata = slots[ridx];
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int         DW        = 16,
  parameter int         DEPTH     = 64,
  parameter int         WORD_MODE = 1,
  parameter int         BLK       = 8,
  parameter int         BUF_MAX   = 32,
  parameter logic [7:0] MFR_CODE  = 8'h89,
  parameter logic [7:0] DEV_CODE  = 8'h15,
  localparam int        AW        = $clog2(DEPTH) + WORD_MODE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_busy
);
  localparam int MAW  = $clog2(DEPTH);
  localparam int BIW  = $clog2(BUF_MAX);
  localparam int CW   = BIW + 1;
  localparam int BLKW = $clog2(BLK + 1);
  localparam int SQW  = (CW > BLKW) ? CW : BLKW;
  localparam int XW   = (MAW + 1 > CW) ? MAW + 1 : CW;

  fstate_e        state_q, state_d;
  logic [DW-1:0]  rdata_q, rdata_d;
  logic [MAW-1:0] start_q, start_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [CW-1:0]  rem_q, rem_d;
  logic [SQW-1:0] seq_q, seq_d;
  logic [MAW-1:0] base_q, base_d;

  logic [MAW-1:0] wa;
  logic           wr_ok, rd_ok;
  logic [7:0]     cmd;
  logic [XW-1:0]  diff;
  logic           in_win;

  logic           mem_we;
  logic [MAW-1:0] mem_wa;
  logic [DW-1:0]  mem_wd, mem_rd;
  logic           buf_we;
  logic [DW-1:0]  buf_rd;

  // Byte-to-word address conversion picked by the mode parameter
  if (WORD_MODE != 0) begin : g_word
    assign wa = bus_addr[AW-1:1];
  end else begin : g_byte
    assign wa = bus_addr;
  end

  assign bus_busy = (state_q == ST_COMMIT) || (state_q == ST_ERASING);
  assign wr_ok    = bus_wr && !bus_busy;
  assign rd_ok    = bus_rd && !bus_wr && !bus_busy;
  assign cmd      = bus_wdata[7:0];
  assign diff     = XW'(wa) - XW'(start_q);
  assign in_win   = (wa >= start_q) && (diff < XW'(cnt_q));
  assign bus_rdata = rdata_q;

  flash_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_wa),
    .wdata (mem_wd),
    .raddr (wa),
    .rdata (mem_rd)
  );

  flash_wbuf #(.DW(DW), .ENTRIES(BUF_MAX)) u_wbuf (
    .clk   (clk),
    .we    (buf_we),
    .widx  (diff[BIW-1:0]),
    .wdata (bus_wdata),
    .ridx  (seq_q[BIW-1:0]),
    .rdata (buf_rd)
  );

  always_comb begin
    state_d = state_q;
    rdata_d = rdata_q;
    start_d = start_q;
    cnt_d   = cnt_q;
    rem_d   = rem_q;
    seq_d   = seq_q;
    base_d  = base_q;
    mem_we  = 1'b0;
    mem_wa  = wa;
    mem_wd  = bus_wdata;
    buf_we  = 1'b0;

    if (wr_ok) begin
      case (state_q)
        ST_ARRAY, ST_ID, ST_PROG_DONE, ST_ERASE_DONE: begin
          state_d = decode_cmd(cmd, state_q);
          if (cmd == CMD_BUFFER) begin
            start_d = wa;
            cnt_d   = '0;
            rem_d   = '0;
          end
        end
        ST_STATUS: state_d = ST_ARRAY;
        ST_PROG: begin
          mem_we  = 1'b1;
          state_d = ST_PROG_DONE;
        end
        ST_BUF_CNT: begin
          cnt_d   = CW'(bus_wdata[BIW-1:0]) + CW'(1);
          rem_d   = CW'(bus_wdata[BIW-1:0]) + CW'(1);
          state_d = ST_BUF_DATA;
        end
        ST_BUF_DATA: begin
          if (in_win) begin
            buf_we = 1'b1;
            rem_d  = rem_q - CW'(1);
            if (rem_q == CW'(1)) state_d = ST_BUF_CONF;
          end
        end
        ST_BUF_CONF: begin
          seq_d   = '0;
          state_d = (cmd == CMD_CONFIRM) ? ST_COMMIT : ST_ARRAY;
        end
        ST_ERASE_ARM: begin
          if (cmd == CMD_CONFIRM) begin
            seq_d   = '0;
            base_d  = wa;
            state_d = ST_ERASING;
          end
        end
        default: ;
      endcase
    end else if (rd_ok) begin
      case (state_q)
        ST_ARRAY: rdata_d = mem_rd;
        ST_ID: begin
          if (wa == MAW'(0))      rdata_d = DW'(MFR_CODE);
          else if (wa == MAW'(1)) rdata_d = DW'(DEV_CODE);
          else                    rdata_d = '0;
        end
        ST_STATUS: begin
          rdata_d = DW'(READY_CODE);
          state_d = ST_ARRAY;
        end
        default: rdata_d = DW'(READY_CODE);
      endcase
    end

    // Multi-cycle sequencer: one location per cycle
    if (state_q == ST_COMMIT) begin
      mem_we = 1'b1;
      mem_wa = start_q + MAW'(seq_q);
      mem_wd = buf_rd;
      seq_d  = seq_q + SQW'(1);
      if (seq_q == SQW'(cnt_q - CW'(1))) state_d = ST_ARRAY;
    end else if (state_q == ST_ERASING) begin
      mem_we = 1'b1;
      mem_wa = base_q + MAW'(seq_q);
      mem_wd = '1;
      seq_d  = seq_q + SQW'(1);
      if (seq_q == SQW'(BLK - 1)) state_d = ST_ERASE_DONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ARRAY;
      rdata_q <= '0;
      start_q <= '0;
      cnt_q   <= '0;
      rem_q   <= '0;
      seq_q   <= '0;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      rdata_q <= rdata_d;
      start_q <= start_d;
      cnt_q   <= cnt_d;
      rem_q   <= rem_d;
      seq_q   <= seq_d;
      base_q  <= base_d;
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
  import flash_cmd_pkg::*;
#(
  parameter int         DW        = 16,
  parameter int         AW        = 7,
  parameter int         WORD_MODE = 1,
  parameter int         BLK       = 8,
  parameter int         BUF_MAX   = 32,
  parameter logic [7:0] MFR_CODE  = 8'h89
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [DW-1:0] bus_rdata,
  input logic          bus_busy,
  input fstate_e       state
);
  localparam int LIM = (BLK > BUF_MAX) ? BLK : BUF_MAX;

  logic [AW-1:0] word_a;
  logic [15:0]   busy_run;
  logic          rd_only, pending;

  assign word_a  = (WORD_MODE != 0) ? (bus_addr >> 1) : bus_addr;
  assign rd_only = bus_rd && !bus_wr && !bus_busy;
  assign pending = (state == ST_PROG) || (state == ST_PROG_DONE) ||
                   (state == ST_BUF_CNT) || (state == ST_BUF_DATA) ||
                   (state == ST_BUF_CONF) || (state == ST_ERASE_ARM) ||
                   (state == ST_ERASE_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy_run <= '0;
    else if (bus_busy) busy_run <= busy_run + 16'd1;
    else               busy_run <= '0;
  end

  // R13
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |=> $stable(bus_rdata));

  // R13
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= 16'(LIM));

  // R12
  pending_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_only && pending) |=> (bus_rdata == DW'(8'h80)));

  // R9
  id_mfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_only && state == ST_ID && word_a == '0) |=> (bus_rdata == DW'(MFR_CODE)));

  // R8
  discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_busy && state == ST_BUF_CONF && bus_wdata[7:0] != 8'hD0)
      |=> (state == ST_ARRAY));

  // R11
  erase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_busy && state == ST_ERASE_ARM && bus_wdata[7:0] != 8'hD0)
      |=> (state == ST_ERASE_ARM));

  // R10
  status_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && !bus_busy && state == ST_STATUS) |=> (state == ST_ARRAY));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(
  .DW(DW), .AW(AW), .WORD_MODE(WORD_MODE), .BLK(BLK), .BUF_MAX(BUF_MAX), .MFR_CODE(MFR_CODE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .bus_busy  (bus_busy),
  .state     (state_q)
);

// File: tb/flash_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_bench;
  localparam int DEPTH = 64;
  localparam int BLK   = 8;
  localparam int AW    = 7;

  localparam int M_ARR = 0, M_ID = 1, M_STAT = 2, M_PROG = 3, M_PDONE = 4,
                 M_CNT = 5, M_DATA = 6, M_CONF = 7, M_EARM = 8, M_EDONE = 9;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic [15:0]   bus_wdata;
  logic          bus_wr, bus_rd;
  logic [15:0]   bus_rdata;
  logic          bus_busy;

  int checks = 0;
  int failures = 0;

  int          mst, bstart, bcnt, brem, busy_left;
  logic [15:0] mmem [DEPTH];
  logic [15:0] mbuf [32];
  logic [15:0] exp_rd;
  logic        exp_busy;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.DW(16), .DEPTH(DEPTH), .WORD_MODE(1), .BLK(BLK),
                   .BUF_MAX(32), .MFR_CODE(8'h89), .DEV_CODE(8'h15)) u_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_busy(bus_busy)
  );

  function automatic void decode(input logic [15:0] d, input int w);
    case (d[7:0])
      8'h40, 8'h10: mst = M_PROG;
      8'hE8: begin mst = M_CNT; bstart = w; end
      8'h70: mst = M_STAT;
      8'h50, 8'hFF: mst = M_ARR;
      8'h90: mst = M_ID;
      8'h20: mst = M_EARM;
      default: ;
    endcase
  endfunction

  // Behavioural reference: advances one clock edge per call
  task automatic model_step(input logic wr, input logic rd, input int addr, input logic [15:0] d);
    int w;
    w = addr >> 1;
    if (busy_left > 0) begin
      busy_left--;
    end else if (wr) begin
      case (mst)
        M_ARR, M_ID, M_PDONE, M_EDONE: decode(d, w);
        M_STAT: mst = M_ARR;
        M_PROG: begin mmem[w] = d; mst = M_PDONE; end
        M_CNT: begin bcnt = int'(d[4:0]) + 1; brem = bcnt; mst = M_DATA; end
        M_DATA: if (w >= bstart && w < bstart + bcnt) begin
          mbuf[w - bstart] = d;
          brem--;
          if (brem == 0) mst = M_CONF;
        end
        M_CONF: begin
          if (d[7:0] == 8'hD0) begin
            for (int i = 0; i < bcnt; i++) mmem[(bstart + i) % DEPTH] = mbuf[i];
            busy_left = bcnt;
          end
          mst = M_ARR;
        end
        M_EARM: if (d[7:0] == 8'hD0) begin
          for (int i = 0; i < BLK; i++) mmem[(w + i) % DEPTH] = 16'hFFFF;
          busy_left = BLK;
          mst = M_EDONE;
        end
        default: ;
      endcase
    end else if (rd) begin
      case (mst)
        M_ARR: exp_rd = mmem[w];
        M_ID: exp_rd = (w == 0) ? 16'h0089 : (w == 1) ? 16'h0015 : 16'h0000;
        M_STAT: begin exp_rd = 16'h0080; mst = M_ARR; end
        default: exp_rd = 16'h0080;
      endcase
    end
    exp_busy = (busy_left > 0);
  endtask

  task automatic cyc(input logic wr, input logic rd, input int addr, input logic [15:0] d,
                     input string tag);
    bus_wr    = wr;
    bus_rd    = rd;
    bus_addr  = AW'(addr);
    bus_wdata = d;
    model_step(wr, rd, addr, d);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (bus_rdata !== exp_rd || bus_busy !== exp_busy) begin
      failures++;
      $display("FAIL %s: rdata=%h busy=%b expected rdata=%h busy=%b",
               tag, bus_rdata, bus_busy, exp_rd, exp_busy);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d, input string tag);
    cyc(1'b1, 1'b0, a, d, tag);
  endtask
  task automatic rd(input int a, input string tag);
    cyc(1'b0, 1'b1, a, 16'h0000, tag);
  endtask
  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 0, 16'h0000, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    mst = M_ARR; bstart = 0; bcnt = 0; brem = 0; busy_left = 0;
    exp_rd = 16'h0000; exp_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1, "R1");

    // R11: erase armed survives a non-confirm write, then erase words 0..7
    wr(0, 16'h0020, "R11");
    wr(0, 16'h0011, "R11");
    rd(0, "R12 erase armed");
    wr(0, 16'h00D0, "R11");
    idle(BLK, "R13 erase busy");
    rd(0, "R12 erase done");
    wr(0, 16'h0020, "R11 decode in erase-done");
    wr(16, 16'h00D0, "R11 erase 8..15");
    idle(BLK, "R13");
    wr(0, 16'h00FF, "R4");
    rd(0, "R11 ones");
    rd(30, "R11 ones upper");

    // R5: single program, both opcodes
    wr(0, 16'h0040, "R5");
    rd(0, "R12 prog armed");
    wr(6, 16'h1234, "R5");
    rd(6, "R12 prog done");
    wr(0, 16'h00FF, "R4");
    rd(7, "R2 odd byte addr");
    wr(0, 16'h0010, "R5");
    wr(10, 16'hBEEF, "R5");
    wr(0, 16'h0090, "R5 decode in prog-done");

    // R9: identifier reads
    rd(0, "R9 mfr");
    rd(2, "R9 dev");
    rd(4, "R9 other");
    wr(0, 16'h12FF, "R3 upper bits ignored");
    rd(10, "R2");
    wr(0, 16'h0033, "R3 unknown cmd");
    rd(6, "R3");

    // R10: status mode
    wr(0, 16'h0070, "R10");
    rd(0, "R10 status read");
    rd(6, "R10 back to array");
    wr(0, 16'h0070, "R10");
    wr(0, 16'h0090, "R10 write not decoded");
    rd(0, "R10");

    // R4: 0x50 leaves identifier mode
    wr(0, 16'h0090, "R4");
    wr(0, 16'h0050, "R4");
    rd(0, "R4");

    // R6 R7 R8: buffered program of 4 words at word 8
    wr(16, 16'h00E8, "R6");
    rd(16, "R12 count");
    wr(0, 16'hFFE3, "R6 count");
    wr(24, 16'h0C0C, "R7 outside high");
    wr(14, 16'h0707, "R7 outside low");
    wr(18, 16'hA009, "R7");
    wr(16, 16'hA008, "R7");
    rd(16, "R12 buffer fill");
    wr(22, 16'hA011, "R7");
    wr(20, 16'hA010, "R7");
    rd(16, "R12 confirm");
    wr(0, 16'h00D0, "R8 commit");
    wr(0, 16'h0090, "R13 ignored write");
    rd(0, "R13 ignored read");
    idle(2, "R13");
    rd(16, "R8");
    rd(18, "R8");
    rd(20, "R8");
    rd(22, "R8");
    rd(24, "R7 untouched");
    rd(14, "R7 untouched");

    // R8: discard path
    wr(0, 16'h00E8, "R6");
    wr(0, 16'h0000, "R6 count 1");
    wr(0, 16'hAAAA, "R7");
    wr(0, 16'h00FF, "R8 discard");
    rd(0, "R8 discard kept");

    idle(1, "R1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule